// File: doc/BRIEF.md
# Four-Register Datapath Driven by a Control Word

This block is the data half of a simple processor. It holds four general registers that are read without a clock onto two operand buses, A and B. Bus B carries either a selected register or an external constant. A function unit combines the two buses and produces a result plus four status flags. The result comes from an arithmetic unit, a bitwise logic unit or a one-bit shifter. A destination path then writes either that result or external input data back into one register on the rising clock edge.

Every choice is made by a set of parallel control inputs that together form the control word. There is no sequencing inside the block. Bus A is also driven out as a memory address and bus B as outgoing data, so an outside sequencer can build load and store transfers from the same fields.

Top module: `rfdp_top`

## Requirements
- R1: An active-low asynchronous reset clears all four registers to 0, even if a write is requested while reset is held.
- R2: `addr_out` equals the register chosen by `a_sel`. `data_out` equals the register chosen by `b_sel` when `b_const_en`=0, and equals `const_in` when `b_const_en`=1.
- R3: When `fn[3]`=0 the operation is arithmetic, with S=`fn[2:1]` and carry-in=`fn[0]`. The result for each code is S=00: A or A+1; S=01: A+B or A+B+1; S=10: A+~B or A+~B+1 (that is, A-B); S=11: A-1 or A. All results are taken modulo 2^W.
- R4: When `fn[3]`=1 the operation is bitwise logic chosen by `fn[1:0]`: 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B, and 11 gives NOT A.
- R5: When `shift_pick`=1 the function result is bus B shifted by one bit, with a 0 filling the vacated bit. `shift_dir`=0 shifts toward the MSB and `shift_dir`=1 shifts toward the LSB. In this case `fn` has no effect on the result.
- R6: When `din_pick`=1, a write stores `data_in` instead of the function result.
- R7: When `wr_en`=1, the register chosen by `dst_sel` takes the destination value on the rising clock edge. When `wr_en`=0, no register changes.
- R8: A register that is read and written in the same cycle shows its old value on the buses until the clock edge.
- R9: `zero_flag` is 1 exactly when the function result is all zeros. `neg_flag` equals the MSB of the function result.
- R10: `carry_flag` is the carry out of the adder. `ovf_flag` is 1 when two operands of the same sign give a sum of the other sign. Both flags are 0 when the logic unit or the shifter supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_sel | input | 2 | Register placed on bus A |
| b_sel | input | 2 | Register offered to the bus B multiplexer |
| b_const_en | input | 1 | 1: bus B carries const_in |
| fn | input | 4 | Function code (see R3, R4) |
| shift_pick | input | 1 | 1: the function result comes from the shifter |
| shift_dir | input | 1 | 0: shift toward the MSB, 1: shift toward the LSB |
| din_pick | input | 1 | 1: the destination value is data_in |
| dst_sel | input | 2 | Register that is written |
| wr_en | input | 1 | Write enable |
| const_in | input | W | Constant operand |
| data_in | input | W | External write data |
| addr_out | output | W | Bus A |
| data_out | output | W | Bus B |
| ovf_flag | output | 1 | Signed overflow |
| carry_flag | output | 1 | Adder carry out |
| neg_flag | output | 1 | Result MSB |
| zero_flag | output | 1 | Result is zero |

## Verification
A register can be a source on bus A and the write destination in the same cycle. The read must still return the old contents while the new value is being captured. The bench provokes this by incrementing a register into itself. It checks that `addr_out` shows the old value in the middle of that cycle and the incremented value in the next cycle. A cycle-level behavioural model then runs a long stream of mixed control words. Many of these cycles again collide reads with writes, and the model judges every bus and flag in each one.

// File: rtl/rfdp_pkg.sv
package rfdp_pkg;

   typedef enum logic [1:0] {
      LG_AND = 2'b00,
      LG_OR  = 2'b01,
      LG_XOR = 2'b10,
      LG_NOT = 2'b11
   } logic_op_e;

   typedef enum logic [1:0] {
      AY_ZERO = 2'b00,
      AY_B    = 2'b01,
      AY_NOTB = 2'b10,
      AY_ONES = 2'b11
   } arith_y_e;

endpackage

// File: rtl/rfdp_regfile.sv
module rfdp_regfile #(
   parameter int W    = 8,
   parameter int NREG = 4,
   localparam int SELW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [SELW-1:0] wsel,
   input  logic [W-1:0]    wdata,
   input  logic [SELW-1:0] asel,
   input  logic [SELW-1:0] bsel,
   output logic [W-1:0]    adata,
   output logic [W-1:0]    bdata
);

   logic [W-1:0] regs [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[i] <= '0;
         else if (we && (wsel == SELW'(i)))
            regs[i] <= wdata;
      end
   end

   assign adata = regs[asel];
   assign bdata = regs[bsel];

endmodule

// File: rtl/rfdp_func_unit.sv
module rfdp_func_unit
   import rfdp_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [3:0]   fn,
   input  logic         shift_pick,
   input  logic         shift_dir,
   output logic [W-1:0] f,
   output logic         carry,
   output logic         ovf,
   output logic         neg,
   output logic         zero
);

   logic [W-1:0] y_opnd;
   logic [W:0]   sum;
   logic [W-1:0] lres;
   logic [W-1:0] sres;
   logic         arith_ovf;
   logic         use_adder;

   always_comb begin
      unique case (arith_y_e'(fn[2:1]))
         AY_ZERO: y_opnd = '0;
         AY_B:    y_opnd = b;
         AY_NOTB: y_opnd = ~b;
         default: y_opnd = '1;
      endcase
   end

   assign sum       = {1'b0, a} + {1'b0, y_opnd} + {{W{1'b0}}, fn[0]};
   assign arith_ovf = (a[W-1] == y_opnd[W-1]) && (sum[W-1] != a[W-1]);

   always_comb begin
      unique case (logic_op_e'(fn[1:0]))
         LG_AND:  lres = a & b;
         LG_OR:   lres = a | b;
         LG_XOR:  lres = a ^ b;
         default: lres = ~a;
      endcase
   end

   assign sres = shift_dir ? {1'b0, b[W-1:1]} : {b[W-2:0], 1'b0};

   assign use_adder = !shift_pick && !fn[3];

   always_comb begin
      if (shift_pick)
         f = sres;
      else if (fn[3])
         f = lres;
      else
         f = sum[W-1:0];
   end

   assign carry = use_adder && sum[W];
   assign ovf   = use_adder && arith_ovf;
   assign neg   = f[W-1];
   assign zero  = (f == '0);

endmodule

// File: rtl/rfdp_top.sv
module rfdp_top #(
   parameter int W    = 8,
   parameter int NREG = 4,
   localparam int SELW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [SELW-1:0] a_sel,
   input  logic [SELW-1:0] b_sel,
   input  logic            b_const_en,
   input  logic [3:0]      fn,
   input  logic            shift_pick,
   input  logic            shift_dir,
   input  logic            din_pick,
   input  logic [SELW-1:0] dst_sel,
   input  logic            wr_en,
   input  logic [W-1:0]    const_in,
   input  logic [W-1:0]    data_in,
   output logic [W-1:0]    addr_out,
   output logic [W-1:0]    data_out,
   output logic            ovf_flag,
   output logic            carry_flag,
   output logic            neg_flag,
   output logic            zero_flag
);

   if (W < 2) begin : g_bad_width
      $error("rfdp_top: W must be at least 2");
   end
   if (NREG < 2 || (1 << SELW) != NREG) begin : g_bad_nreg
      $error("rfdp_top: NREG must be a power of two of at least 2");
   end

   logic [W-1:0] bus_a;
   logic [W-1:0] reg_b;
   logic [W-1:0] bus_b;
   logic [W-1:0] bus_f;
   logic [W-1:0] bus_d;

   rfdp_regfile #(.W(W), .NREG(NREG)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .wsel  (dst_sel),
      .wdata (bus_d),
      .asel  (a_sel),
      .bsel  (b_sel),
      .adata (bus_a),
      .bdata (reg_b)
   );

   assign bus_b = b_const_en ? const_in : reg_b;

   rfdp_func_unit #(.W(W)) u_fu (
      .a          (bus_a),
      .b          (bus_b),
      .fn         (fn),
      .shift_pick (shift_pick),
      .shift_dir  (shift_dir),
      .f          (bus_f),
      .carry      (carry_flag),
      .ovf        (ovf_flag),
      .neg        (neg_flag),
      .zero       (zero_flag)
   );

   assign bus_d    = din_pick ? data_in : bus_f;
   assign addr_out = bus_a;
   assign data_out = bus_b;

endmodule

// File: rtl/rfdp_chk.sv
module rfdp_chk #(
   parameter int W    = 8,
   parameter int SELW = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic [SELW-1:0] a_sel,
   input logic [SELW-1:0] dst_sel,
   input logic            wr_en,
   input logic            din_pick,
   input logic            shift_pick,
   input logic [3:0]      fn,
   input logic            b_const_en,
   input logic [W-1:0]    data_in,
   input logic [W-1:0]    bus_d,
   input logic [W-1:0]    addr_out,
   input logic [W-1:0]    data_out,
   input logic            ovf_flag,
   input logic            carry_flag,
   input logic            neg_flag,
   input logic            zero_flag
);

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (addr_out == '0) && (b_const_en || data_out == '0)); // R1

   AST_LOAD_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (a_sel != $past(dst_sel)) || (addr_out == $past(bus_d))); // R7

   AST_NO_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (a_sel != $past(a_sel)) || (addr_out == $past(addr_out))); // R7

   AST_DIN_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && din_pick) |=> (a_sel != $past(dst_sel)) || (addr_out == $past(data_in))); // R6

   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !din_pick) |=> (a_sel != $past(dst_sel)) || ((addr_out == '0) == $past(zero_flag))); // R9

   AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !din_pick) |=> (a_sel != $past(dst_sel)) || (addr_out[W-1] == $past(neg_flag))); // R9

   AST_ADDER_ONLY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag || carry_flag) |-> (!shift_pick && !fn[3])); // R10

endmodule

bind rfdp_top rfdp_chk #(.W(W), .SELW(SELW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .a_sel      (a_sel),
   .dst_sel    (dst_sel),
   .wr_en      (wr_en),
   .din_pick   (din_pick),
   .shift_pick (shift_pick),
   .fn         (fn),
   .b_const_en (b_const_en),
   .data_in    (data_in),
   .bus_d      (bus_d),
   .addr_out   (addr_out),
   .data_out   (data_out),
   .ovf_flag   (ovf_flag),
   .carry_flag (carry_flag),
   .neg_flag   (neg_flag),
   .zero_flag  (zero_flag)
);

// File: tb/sim_rfdp_top.sv
module sim_rfdp_top;

   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   a_sel = '0, b_sel = '0, dst_sel = '0;
   logic         b_const_en = 1'b0, shift_pick = 1'b0, shift_dir = 1'b0;
   logic         din_pick = 1'b0, wr_en = 1'b0;
   logic [3:0]   fn = '0;
   logic [W-1:0] const_in = '0, data_in = '0;
   logic [W-1:0] addr_out, data_out;
   logic         ovf_flag, carry_flag, neg_flag, zero_flag;

   int total = 0;
   int bad = 0;
   logic [W-1:0] mreg [4];
   logic [W-1:0] mid_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   rfdp_top u0 (
      .clk(clk), .rst_n(rst_n), .a_sel(a_sel), .b_sel(b_sel),
      .b_const_en(b_const_en), .fn(fn), .shift_pick(shift_pick),
      .shift_dir(shift_dir), .din_pick(din_pick), .dst_sel(dst_sel),
      .wr_en(wr_en), .const_in(const_in), .data_in(data_in),
      .addr_out(addr_out), .data_out(data_out), .ovf_flag(ovf_flag),
      .carry_flag(carry_flag), .neg_flag(neg_flag), .zero_flag(zero_flag)
   );

   task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
      end
   endtask

   // Behavioural model of the result: returns {ovf, carry, f}
   function automatic logic [W+1:0] model_fn(int a, int b);
      int mask = (1 << W) - 1;
      int y, s, r;
      logic c, v;
      c = 1'b0; v = 1'b0;
      if (shift_pick) begin
         r = shift_dir ? (b >> 1) : ((b << 1) & mask);
      end else if (fn[3]) begin
         case (fn[1:0])
            2'd0: r = a & b;
            2'd1: r = a | b;
            2'd2: r = a ^ b;
            default: r = (~a) & mask;
         endcase
      end else begin
         case (fn[2:1])
            2'd0: y = 0;
            2'd1: y = b;
            2'd2: y = (~b) & mask;
            default: y = mask;
         endcase
         s = a + y + int'(fn[0]);
         r = s & mask;
         c = (s >> W) != 0;
         v = (((a >> (W-1)) & 1) == ((y >> (W-1)) & 1)) &&
             (((r >> (W-1)) & 1) != ((a >> (W-1)) & 1));
      end
      return {v, c, W'(r)};
   endfunction

   task automatic drive(input logic [1:0] as, input logic [1:0] bs, input logic bc,
                        input logic [3:0] f, input logic sp, input logic sd,
                        input logic dp, input logic [1:0] ds, input logic we,
                        input logic [W-1:0] k, input logic [W-1:0] di);
      logic [W+1:0] m;
      int bv;
      @(negedge clk);
      a_sel = as; b_sel = bs; b_const_en = bc; fn = f; shift_pick = sp;
      shift_dir = sd; din_pick = dp; dst_sel = ds; wr_en = we;
      const_in = k; data_in = di;
      #1;
      bv = bc ? int'(k) : int'(mreg[bs]);
      m = model_fn(int'(mreg[as]), bv);
      mid_addr = addr_out;
      check("R2 addr_out", addr_out, mreg[as]);
      check("R2 data_out", data_out, W'(bv));
      check("R9 zero", W'(zero_flag), W'(m[W-1:0] == '0));
      check("R9 neg", W'(neg_flag), W'(m[W-1]));
      check("R10 carry", W'(carry_flag), W'(m[W]));
      check("R10 ovf", W'(ovf_flag), W'(m[W+1]));
      @(posedge clk);
      if (we) mreg[ds] = dp ? di : m[W-1:0];
   endtask

   task automatic idle_read(input logic [1:0] as);
      drive(as, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, '0, '0);
      #1;
   endtask

   // Run op into scratch register 0, then read it back
   task automatic op_rd(string tag, input logic [1:0] as, input logic [1:0] bs,
                        input logic bc, input logic [3:0] f, input logic sp,
                        input logic sd, input logic [W-1:0] k, input logic [W-1:0] exp);
      drive(as, bs, bc, f, sp, sd, 1'b0, 2'd0, 1'b1, k, '0);
      idle_read(2'd0);
      check(tag, addr_out, exp);
   endtask

   task automatic load(input logic [1:0] ds, input logic [W-1:0] v);
      drive(2'd0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1, ds, 1'b1, '0, v);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) mreg[i] = '0;
      // write requested during reset must be ignored
      wr_en = 1'b1; din_pick = 1'b1; data_in = 8'hFF; dst_sel = 2'd1;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1; wr_en = 1'b0;
      for (int i = 0; i < 4; i++) begin
         idle_read(2'(i));
         check("R1 reset value", addr_out, 8'h00);
      end

      load(2'd0, 8'h80); load(2'd1, 8'h7F); load(2'd2, 8'h35); load(2'd3, 8'h0C);
      idle_read(2'd2);
      check("R6 data_in load", addr_out, 8'h35);
      drive(2'd1, 2'd3, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 8'hA5, '0);
      #1; check("R2 constant on bus B", data_out, 8'hA5);

      // R3 arithmetic with A=R2=35, B=R3=0C
      op_rd("R3 A",      2'd2, 2'd3, 1'b0, 4'b0000, 1'b0, 1'b0, '0, 8'h35);
      op_rd("R3 A+1",    2'd2, 2'd3, 1'b0, 4'b0001, 1'b0, 1'b0, '0, 8'h36);
      op_rd("R3 A+B",    2'd2, 2'd3, 1'b0, 4'b0010, 1'b0, 1'b0, '0, 8'h41);
      op_rd("R3 A+B+1",  2'd2, 2'd3, 1'b0, 4'b0011, 1'b0, 1'b0, '0, 8'h42);
      op_rd("R3 A+~B",   2'd2, 2'd3, 1'b0, 4'b0100, 1'b0, 1'b0, '0, 8'h28);
      op_rd("R3 A-B",    2'd2, 2'd3, 1'b0, 4'b0101, 1'b0, 1'b0, '0, 8'h29);
      op_rd("R3 A-1",    2'd2, 2'd3, 1'b0, 4'b0110, 1'b0, 1'b0, '0, 8'h34);
      op_rd("R3 A pass", 2'd2, 2'd3, 1'b0, 4'b0111, 1'b0, 1'b0, '0, 8'h35);
      // R4 logic
      op_rd("R4 AND", 2'd2, 2'd3, 1'b0, 4'b1000, 1'b0, 1'b0, '0, 8'h04);
      op_rd("R4 OR",  2'd2, 2'd3, 1'b0, 4'b1001, 1'b0, 1'b0, '0, 8'h3D);
      op_rd("R4 XOR", 2'd2, 2'd3, 1'b0, 4'b1010, 1'b0, 1'b0, '0, 8'h39);
      op_rd("R4 NOT", 2'd2, 2'd3, 1'b0, 4'b1011, 1'b0, 1'b0, '0, 8'hCA);
      // R5 shifter, fn set to something that must not matter
      op_rd("R5 shift left",  2'd2, 2'd3, 1'b0, 4'b1011, 1'b1, 1'b0, '0, 8'h18);
      op_rd("R5 shift right", 2'd2, 2'd3, 1'b0, 4'b0011, 1'b1, 1'b1, '0, 8'h06);
      op_rd("R5 const left",  2'd2, 2'd3, 1'b1, 4'b0010, 1'b1, 1'b0, 8'h81, 8'h02);
      op_rd("R5 const right", 2'd2, 2'd3, 1'b1, 4'b0010, 1'b1, 1'b1, 8'h81, 8'h40);

      // R10 signed overflow: 7F + 01
      drive(2'd1, 2'd0, 1'b1, 4'b0010, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 8'h01, '0);
      #1;
      check("R10 ovf on 7F+01", W'(ovf_flag), 8'h01);
      check("R10 no carry on 7F+01", W'(carry_flag), 8'h00);
      check("R9 neg on 7F+01", W'(neg_flag), 8'h01);
      // R9 zero with carry: 7F + 81
      drive(2'd1, 2'd0, 1'b1, 4'b0010, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 8'h81, '0);
      #1;
      check("R9 zero on 7F+81", W'(zero_flag), 8'h01);
      check("R10 carry on 7F+81", W'(carry_flag), 8'h01);
      check("R10 no ovf on 7F+81", W'(ovf_flag), 8'h00);
      // R10 logic clears adder flags even when the adder would carry
      drive(2'd1, 2'd0, 1'b1, 4'b1010, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 8'h81, '0);
      #1; check("R10 logic carry", W'(carry_flag), 8'h00);

      // R7 write disabled: try to overwrite R2
      drive(2'd0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, '0, 8'hEE);
      idle_read(2'd2);
      check("R7 no write when disabled", addr_out, 8'h35);
      // R7 example: R1 <- R2 + R3
      drive(2'd2, 2'd3, 1'b0, 4'b0010, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, '0, '0);
      idle_read(2'd1);
      check("R7 R1=R2+R3", addr_out, 8'h41);
      // R8 increment R2 into itself
      drive(2'd2, 2'd3, 1'b0, 4'b0001, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, '0, '0);
      check("R8 old value during write", mid_addr, 8'h35);
      idle_read(2'd2);
      check("R8 new value after edge", addr_out, 8'h36);

      // mixed stream judged by the model
      for (int n = 0; n < 3000; n++) begin
         drive(2'($urandom), 2'($urandom), 1'($urandom), 4'($urandom),
               1'(($urandom % 4) == 0), 1'($urandom), 1'(($urandom % 5) == 0),
               2'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule